// File: doc/BRIEF.md
# Programmable Wait-State Generator

This block stretches external bus cycles according to the memory region being accessed. A cycle consists of three phases, T1, T2 and T3, which always run in that order. Each phase lasts one base clock plus a number of extra wait clocks. There are three regions: lower, middle and upper. Each region has its own 8-bit delay word, and that word sets the extra clocks for each phase separately.

Address decoding supplies a region code and a one-clock start strobe. The block reports which phase the current clock belongs to. It raises a wait flag while a phase is being held, and it pulses a done flag on the final clock of T3. Delay words are written through a simple write port. When a cycle starts, the block captures the selected word, so a write made later only affects cycles that begin afterwards.

Top module: `waitgen_top`

## Requirements
- R1: After reset, phase is 2'b00 (idle), waitActive and cycleDone are low, and all three delay words are zero, so every cycle lasts exactly three clocks.
- R2: A cycleStart high at a rising edge while idle, or on the done clock, puts phase in T1 from that edge on. A cycleStart on any other clock of a cycle is ignored and leaves the cycle unchanged.
- R3: The phase output is encoded 2'b01 for T1, 2'b10 for T2 and 2'b11 for T3, and it steps through T1, T2, T3 and then back to idle, with no phase skipped.
- R4: Bits 7:5 of a delay word give the count of extra clocks in T1 (0 to 7). For example, 8'hA0 makes T1 last six clocks and leaves T2 and T3 at one clock each.
- R5: Bits 4:3 of a delay word give the count of extra clocks in T2 (0 to 3).
- R6: Bits 2:0 of a delay word give the count of extra clocks in T3 (0 to 7).
- R7: Region codes are 0 for lower, 1 for middle and 2 for upper. A regionSel value of 3 uses the upper word. A write with cfgWrSel equal to 3 changes no delay word.
- R8: The delay word is captured at the start edge. A write during a cycle, or at the very edge on which the cycle starts, only affects cycles that start later.
- R9: waitActive is high on every clock of a phase except its last clock, and low while idle.
- R10: cycleDone is high for exactly the last clock of T3. A start on that clock begins the next T1 with no idle clock between the two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleStart | input | 1 | Start a bus cycle |
| regionSel | input | 2 | Region of the access being started |
| cfgWrEn | input | 1 | Write strobe for a delay word |
| cfgWrSel | input | 2 | Region whose delay word is written |
| cfgWrData | input | 8 | Delay word value |
| phase | output | 2 | Current phase (idle, T1, T2, T3) |
| waitActive | output | 1 | The current phase is being held |
| cycleDone | output | 1 | Last clock of the cycle |

## Verification
The hardest cases to reach are the timing collisions. One is a delay-word write that lands on the same edge as the start of a cycle using that word. Another is a start strobe that arrives on the done clock, or in the middle of a cycle. The stimulus reaches these by counting clocks from a known start edge: the expected length of the cycle is known, so the driver can place the write or the second strobe on exactly the clock it wants. The scoreboard then compares every clock of both cycles.

// File: rtl/waitgen_pkg.sv
package waitgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_T1   = 2'b01,
    PH_T2   = 2'b10,
    PH_T3   = 2'b11
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startCycle;  // capture selected word, load T1 count
    logic loadT2;      // load T2 count from captured word
    logic loadT3;      // load T3 count from captured word
    logic decCnt;      // consume one wait clock
  } ctrlStrobes_t;

endpackage

// File: rtl/waitgen_dp.sv
module waitgen_dp
  import waitgen_pkg::*;
#(
  parameter int NUM_REGIONS = 3,
  parameter int SEL_W       = 2,
  parameter int T1_BITS     = 3,
  parameter int T2_BITS     = 2,
  parameter int T3_BITS     = 3,
  localparam int CFG_W      = T1_BITS + T2_BITS + T3_BITS,
  localparam int CNT_W      = (T1_BITS > T2_BITS) ?
                              ((T1_BITS > T3_BITS) ? T1_BITS : T3_BITS) :
                              ((T2_BITS > T3_BITS) ? T2_BITS : T3_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [SEL_W-1:0] regionSel,
  input  logic             cfgWrEn,
  input  logic [SEL_W-1:0] cfgWrSel,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             cntZero
);

  localparam int T3_LO = 0;
  localparam int T2_LO = T3_BITS;
  localparam int T1_LO = T3_BITS + T2_BITS;

  logic [CFG_W-1:0] cfgRegs [NUM_REGIONS];
  logic [CFG_W-1:0] cfgSel;
  logic [CFG_W-1:0] cfgLatched;
  logic [CNT_W-1:0] waitCnt;

  // one delay word per region
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgRegs[g] <= '0;
      end else if (cfgWrEn && (int'(cfgWrSel) == g)) begin
        cfgRegs[g] <= cfgWrData;
      end
    end
  end

  // out-of-range region codes fall to the top region
  always_comb begin
    if (int'(regionSel) >= NUM_REGIONS) cfgSel = cfgRegs[NUM_REGIONS-1];
    else                                cfgSel = cfgRegs[regionSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLatched <= '0;
      waitCnt    <= '0;
    end else if (strobes.startCycle) begin
      cfgLatched <= cfgSel;
      waitCnt    <= CNT_W'(cfgSel[T1_LO +: T1_BITS]);
    end else if (strobes.loadT2) begin
      waitCnt    <= CNT_W'(cfgLatched[T2_LO +: T2_BITS]);
    end else if (strobes.loadT3) begin
      waitCnt    <= CNT_W'(cfgLatched[T3_LO +: T3_BITS]);
    end else if (strobes.decCnt) begin
      waitCnt    <= waitCnt - 1'b1;
    end
  end

  assign cntZero = (waitCnt == '0);

endmodule

// File: rtl/waitgen_ctrl.sv
module waitgen_ctrl
  import waitgen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cycleStart,
  input  logic         cntZero,
  output ctrlStrobes_t strobes,
  output phase_t       phase,
  output logic         waitActive,
  output logic         cycleDone
);

  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    unique case (phase)
      PH_IDLE: begin
        if (cycleStart) begin
          phaseNext          = PH_T1;
          strobes.startCycle = 1'b1;
        end
      end
      PH_T1: begin
        if (!cntZero) strobes.decCnt = 1'b1;
        else begin
          phaseNext      = PH_T2;
          strobes.loadT2 = 1'b1;
        end
      end
      PH_T2: begin
        if (!cntZero) strobes.decCnt = 1'b1;
        else begin
          phaseNext      = PH_T3;
          strobes.loadT3 = 1'b1;
        end
      end
      PH_T3: begin
        if (!cntZero) strobes.decCnt = 1'b1;
        else if (cycleStart) begin
          phaseNext          = PH_T1;
          strobes.startCycle = 1'b1;
        end else begin
          phaseNext = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign waitActive = (phase != PH_IDLE) && !cntZero;
  assign cycleDone  = (phase == PH_T3) && cntZero;

endmodule

// File: rtl/waitgen_top.sv
module waitgen_top
  import waitgen_pkg::*;
#(
  parameter int NUM_REGIONS = 3,
  parameter int SEL_W       = 2,
  parameter int T1_BITS     = 3,
  parameter int T2_BITS     = 2,
  parameter int T3_BITS     = 3,
  localparam int CFG_W      = T1_BITS + T2_BITS + T3_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStart,
  input  logic [SEL_W-1:0] regionSel,
  input  logic             cfgWrEn,
  input  logic [SEL_W-1:0] cfgWrSel,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [1:0]       phase,
  output logic             waitActive,
  output logic             cycleDone
);

  ctrlStrobes_t strobes;
  logic         cntZero;
  phase_t       phaseInt;

  waitgen_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .cntZero    (cntZero),
    .strobes    (strobes),
    .phase      (phaseInt),
    .waitActive (waitActive),
    .cycleDone  (cycleDone)
  );

  waitgen_dp #(
    .NUM_REGIONS (NUM_REGIONS),
    .SEL_W       (SEL_W),
    .T1_BITS     (T1_BITS),
    .T2_BITS     (T2_BITS),
    .T3_BITS     (T3_BITS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regionSel  (regionSel),
    .cfgWrEn    (cfgWrEn),
    .cfgWrSel   (cfgWrSel),
    .cfgWrData  (cfgWrData),
    .cntZero    (cntZero)
  );

  assign phase = phaseInt;

endmodule

// File: rtl/waitgen_checker.sv
module waitgen_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cycleStart,
  input logic [1:0] phase,
  input logic       waitActive,
  input logic       cycleDone
);

  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b00 && cycleStart) |=> (phase == 2'b01));

  p_t2_after_t1_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b10) |-> ($past(phase) == 2'b01 || $past(phase) == 2'b10));

  p_t3_after_t2_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b11) |-> ($past(phase) == 2'b10 || $past(phase) == 2'b11));

  p_hold_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    waitActive |=> $stable(phase));

  p_idle_no_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b00) |-> !waitActive && !cycleDone);

  p_done_in_t3_r10: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (phase == 2'b11));

  p_done_leaves_t3_r10: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> (phase != 2'b11));

  p_back_to_back_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && cycleStart) |=> (phase == 2'b01));

endmodule

bind waitgen_top waitgen_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cycleStart (cycleStart),
  .phase      (phase),
  .waitActive (waitActive),
  .cycleDone  (cycleDone)
);

// File: tb/waitgen_top_tb_top.sv
module waitgen_top_tb_top;

  typedef struct {
    logic [1:0] ph;
    logic       wt;
    logic       dn;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleStart = 1'b0;
  logic [1:0] regionSel = '0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgWrSel = '0;
  logic [7:0] cfgWrData = '0;
  logic [1:0] phase;
  logic       waitActive;
  logic       cycleDone;

  int checks = 0;
  int fails  = 0;
  item_t expQ[$];
  logic [7:0] model [3];
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  waitgen_top dut_i (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .regionSel(regionSel),
    .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel), .cfgWrData(cfgWrData),
    .phase(phase), .waitActive(waitActive), .cycleDone(cycleDone)
  );

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {phase,wait,done} actual %b expected %b at %0t",
               tag, act, exp, $time);
    end
  endtask

  // monitor: compare every clock against the scoreboard, idle when empty
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(it.tag, {phase, waitActive, cycleDone}, {it.ph, it.wt, it.dn});
      end else begin
        check("R2 idle", {phase, waitActive, cycleDone}, 4'b0000);
      end
    end
  end

  function automatic void pushPhase(logic [1:0] ph, int extra, string tag);
    for (int i = 0; i < extra; i++) expQ.push_back('{ph, 1'b1, 1'b0, tag});
    expQ.push_back('{ph, 1'b0, (ph == 2'b11), tag});
  endfunction

  // computes the cycle length from a delay word
  function automatic int cycLen(logic [7:0] w);
    return 3 + int'(w[7:5]) + int'(w[4:3]) + int'(w[2:0]);
  endfunction

  // called at posedge+1; holds start over one edge, then queues the cycle
  task automatic doCycle(logic [1:0] sel, string tag, output int len);
    logic [7:0] w;
    w = model[(sel > 2'd2) ? 2 : sel];
    cycleStart = 1'b1;
    regionSel  = sel;
    @(posedge clk); #1;
    cycleStart = 1'b0;
    pushPhase(2'b01, int'(w[7:5]), tag);
    pushPhase(2'b10, int'(w[4:3]), tag);
    pushPhase(2'b11, int'(w[2:0]), tag);
    len = cycLen(w);
  endtask

  task automatic writeCfg(logic [1:0] sel, logic [7:0] data);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = data;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    if (sel <= 2'd2) model[sel] = data;
  endtask

  task automatic fullCycle(logic [1:0] sel, string tag);
    int n;
    doCycle(sel, tag, n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 3; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset", {phase, waitActive, cycleDone}, 4'b0000);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R1/R3: default three-clock cycles in all regions
    fullCycle(2'd0, "R1 R3 default lower");
    fullCycle(2'd2, "R1 default upper");
    // R4: T1 field, example word
    writeCfg(2'd0, 8'hA0);
    fullCycle(2'd0, "R4 T1 extra");
    // R5 / R6 in other regions
    writeCfg(2'd1, 8'b000_11_000);
    fullCycle(2'd1, "R5 T2 extra");
    writeCfg(2'd2, 8'b000_00_111);
    fullCycle(2'd2, "R6 T3 extra");
    // R7: region 3 aliases upper; write to sel 3 ignored
    fullCycle(2'd3, "R7 sel3 upper");
    writeCfg(2'd3, 8'hFF);
    fullCycle(2'd0, "R7 lower kept");
    fullCycle(2'd1, "R7 middle kept");
    fullCycle(2'd2, "R7 upper kept");
    // R9: all fields maximal, mixed
    writeCfg(2'd1, 8'hFF);
    fullCycle(2'd1, "R9 max word");
    writeCfg(2'd1, 8'b010_01_001);
    fullCycle(2'd1, "R9 mixed word");
    // R8: write mid-cycle affects only next cycle
    doCycle(2'd0, "R8 mid write old", n);
    writeCfg(2'd0, 8'b001_00_010);
    repeat (n - 1) @(posedge clk);
    #1;
    fullCycle(2'd0, "R8 mid write new");
    // R8: write on the start edge itself is not seen by that cycle
    begin
      logic [7:0] oldW;
      oldW = model[2];
      cfgWrEn = 1'b1; cfgWrSel = 2'd2; cfgWrData = 8'b011_10_000;
      doCycle(2'd2, "R8 start-edge write old", n);
      cfgWrEn = 1'b0;
      if (n != cycLen(oldW)) check("R8 len", 4'(n), 4'(cycLen(oldW)));
      model[2] = 8'b011_10_000;
      repeat (n) @(posedge clk);
      #1;
      fullCycle(2'd2, "R8 start-edge write new");
    end
    // R2: start mid-cycle ignored
    doCycle(2'd0, "R2 ignore start", n);
    cycleStart = 1'b1; regionSel = 2'd1;
    @(posedge clk); #1;
    cycleStart = 1'b0;
    repeat (n - 1) @(posedge clk);
    #1;
    // R10: back-to-back, start on done clock
    doCycle(2'd1, "R10 first", n);
    repeat (n - 1) @(posedge clk);
    #1;
    doCycle(2'd0, "R10 second", n);
    repeat (n - 1) @(posedge clk);
    #1;
    doCycle(2'd2, "R10 third", n);
    repeat (n) @(posedge clk);
    #1;
    repeat (2) @(posedge clk);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule